// File: doc/BRIEF.md
# Coherence Transition Checker

This block sits beside one node's MSI cache controller and checks, while the system runs, every stable-state change the controller reports for a cache line. It keeps its own small copy of the architected line state in a tag store. For each reported transition it confirms that the claimed starting state matches that copy. It then works out, from the stored state and the triggering event, which final state and which action a plain three-state MSI protocol would produce, and compares both with what the controller reported.

A transition that passes all three comparisons updates the tag store. If it is one of the four changes that other nodes must hear about, it also places a record in a small send queue, which feeds the node's validation bus. A transition that fails any comparison sets a sticky error flag, adds its cause bit to a cause vector, and changes neither the tag store nor the queue. When the queue is full the checker stops accepting reports, which holds the controller back.

Top module: `coh_xn_checker`

## Requirements
- R1: After reset `xn_ready` is 1, `err_flag` is 0, `err_cause` is 000 and `asrt_valid` is 0.
- R2: The stored state of an address whose tag store slot holds a different tag, or nothing, is Invalid. State codes are Invalid 00, Shared 01, Modified 10. A report whose `xn_init` differs from the stored state sets `err_cause[0]`.
- R3: Next state, with event codes local read 000, local write 001, snooped read 010, snooped exclusive read 011, replacement 100. Invalid goes to Shared on a local read and to Modified on a local write. Shared goes to Modified on a local write and to Invalid on a snooped exclusive read or a replacement. Modified goes to Shared on a snooped read and to Invalid on a snooped exclusive read or a replacement. Every other pair keeps its state. A mismatching `xn_final` sets `err_cause[1]`.
- R4: Action codes are none 00, send data 01, respond shared 10, writeback 11. Modified on a snooped read or a snooped exclusive read gives send data. Modified on a replacement gives writeback. Shared on a snooped read gives respond shared. All other pairs give none. A mismatching `xn_act` sets `err_cause[2]`.
- R5: `err_flag` and the bits of `err_cause` stay set until reset. They take effect one cycle after the offending report is accepted.
- R6: Only a report with no mismatch changes the tag store, and only when the state changes. A rejected report leaves the stored state as it was.
- R7: A passing report enqueues its address and a kind code on exactly four changes: Invalid to Shared (00), Invalid to Modified (01), Shared to Modified (10) and Modified to Invalid (11). Modified to Shared and changes that keep the state enqueue nothing.
- R8: The send queue holds 4 records and delivers them in arrival order. `xn_ready` is 0 while it holds 4, and the head stays stable while `asrt_ready` is 0.
- R9: The tag store is direct-indexed by `xn_addr[3:0]` with 16 slots. Writing an address evicts a different address that shares its slot, and the evicted address then reads as Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xn_valid | input | 1 | A transition report is offered |
| xn_ready | output | 1 | Report accepted this cycle when high with xn_valid |
| xn_addr | input | 16 | Line address of the report |
| xn_init | input | 2 | Claimed initial state |
| xn_final | input | 2 | Claimed final state |
| xn_event | input | 3 | Triggering event code |
| xn_act | input | 2 | Claimed action code |
| err_flag | output | 1 | Sticky error indicator |
| err_cause | output | 3 | Sticky cause bits: initial, final, action |
| asrt_valid | output | 1 | Send queue head is valid |
| asrt_ready | input | 1 | Validation bus takes the head record |
| asrt_addr | output | 16 | Address of the head record |
| asrt_kind | output | 2 | Kind code of the head record |

## Verification
An accepted report changes `err_flag`, `err_cause`, the queue head and the stored state at the next rising edge. `xn_ready` follows the queue fill level with no extra delay, so it falls in the cycle after the fourth record is written and rises in the cycle after a pop from a full queue. The bench drives each report just after a falling edge and advances a behavioural model as that report meets the next rising edge. At the following falling edge it compares every output with the model, so each result is sampled in the first cycle it is due. Stalled reports are offered again until accepted, which checks both the cycle in which backpressure starts and the cycle in which it ends.

// File: rtl/cxc_pkg.sv
package cxc_pkg;

   typedef logic [1:0] line_st_t;
   typedef logic [1:0] line_act_t;
   typedef logic [2:0] line_ev_t;
   typedef logic [1:0] asrt_kind_t;

   localparam line_st_t ST_INV = 2'b00;
   localparam line_st_t ST_SHR = 2'b01;
   localparam line_st_t ST_MOD = 2'b10;

   localparam line_ev_t EV_LRD  = 3'b000;
   localparam line_ev_t EV_LWR  = 3'b001;
   localparam line_ev_t EV_SRD  = 3'b010;
   localparam line_ev_t EV_SRDX = 3'b011;
   localparam line_ev_t EV_REPL = 3'b100;

   localparam line_act_t ACT_NONE = 2'b00;
   localparam line_act_t ACT_DATA = 2'b01;
   localparam line_act_t ACT_SHRD = 2'b10;
   localparam line_act_t ACT_WB   = 2'b11;

   localparam asrt_kind_t K_I2S = 2'b00;
   localparam asrt_kind_t K_I2M = 2'b01;
   localparam asrt_kind_t K_S2M = 2'b10;
   localparam asrt_kind_t K_M2I = 2'b11;

   localparam int CAUSE_W = 3;

endpackage

// File: rtl/cxc_rules.sv
module cxc_rules
   import cxc_pkg::*;
(
   input  line_st_t   cur_st,
   input  line_ev_t   ev,
   output line_st_t   nxt_st,
   output line_act_t  nxt_act,
   output logic       need_asrt,
   output asrt_kind_t asrt_kind
);

   always_comb begin
      nxt_st  = cur_st;
      nxt_act = ACT_NONE;
      unique case (cur_st)
         ST_INV: begin
            if (ev == EV_LRD)      nxt_st = ST_SHR;
            else if (ev == EV_LWR) nxt_st = ST_MOD;
         end
         ST_SHR: begin
            if (ev == EV_LWR)                         nxt_st = ST_MOD;
            else if (ev == EV_SRDX || ev == EV_REPL)  nxt_st = ST_INV;
            else if (ev == EV_SRD)                    nxt_act = ACT_SHRD;
         end
         ST_MOD: begin
            if (ev == EV_SRD) begin
               nxt_st  = ST_SHR;
               nxt_act = ACT_DATA;
            end else if (ev == EV_SRDX) begin
               nxt_st  = ST_INV;
               nxt_act = ACT_DATA;
            end else if (ev == EV_REPL) begin
               nxt_st  = ST_INV;
               nxt_act = ACT_WB;
            end
         end
         default: begin
            nxt_st  = cur_st;
            nxt_act = ACT_NONE;
         end
      endcase
   end

   always_comb begin
      need_asrt = 1'b0;
      asrt_kind = K_I2S;
      unique case ({cur_st, nxt_st})
         {ST_INV, ST_SHR}: begin need_asrt = 1'b1; asrt_kind = K_I2S; end
         {ST_INV, ST_MOD}: begin need_asrt = 1'b1; asrt_kind = K_I2M; end
         {ST_SHR, ST_MOD}: begin need_asrt = 1'b1; asrt_kind = K_S2M; end
         {ST_MOD, ST_INV}: begin need_asrt = 1'b1; asrt_kind = K_M2I; end
         default: begin need_asrt = 1'b0; asrt_kind = K_I2S; end
      endcase
   end

endmodule

// File: rtl/cxc_tag_store.sv
module cxc_tag_store
   import cxc_pkg::*;
#(
   parameter int ENTRIES      = 16,
   parameter int TAG_W        = 12,
   parameter bit CLEAR_ON_INV = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(ENTRIES)-1:0] rd_idx,
   output logic [TAG_W-1:0]           rd_tag,
   output logic                       rd_vld,
   output line_st_t                   rd_st,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic [TAG_W-1:0]           wr_tag,
   input  line_st_t                   wr_st
);

   localparam int IDX_W = $clog2(ENTRIES);

   logic [TAG_W-1:0] tag_q [ENTRIES];
   logic             vld_q [ENTRIES];
   line_st_t         st_q  [ENTRIES];
   logic             wr_vld;

   generate
      if (CLEAR_ON_INV) begin : g_clear
         assign wr_vld = (wr_st != ST_INV);
      end else begin : g_keep
         assign wr_vld = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            st_q[i]  <= ST_INV;
         end
      end else if (wr_en) begin
         vld_q[wr_idx] <= wr_vld;
         tag_q[wr_idx] <= wr_tag;
         st_q[wr_idx]  <= wr_st;
      end
   end

   assign rd_tag = tag_q[rd_idx];
   assign rd_vld = vld_q[rd_idx];
   assign rd_st  = st_q[rd_idx];

   if (IDX_W < 1) begin : g_bad_entries
      $error("cxc_tag_store: ENTRIES must be at least 2");
   end

endmodule

// File: rtl/cxc_asrt_fifo.sv
module cxc_asrt_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] cnt
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_p, rd_p;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_p  <= '0;
         rd_p  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
         if (do_pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
         unique case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= din;
   end

   assign dout  = mem[rd_p];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign cnt   = cnt_q;

endmodule

// File: rtl/coh_xn_checker.sv
module coh_xn_checker
   import cxc_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int TAG_ENTRIES  = 16,
   parameter int Q_DEPTH      = 4,
   parameter bit CLEAR_ON_INV = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        xn_valid,
   output logic        xn_ready,
   input  logic [ADDR_W-1:0] xn_addr,
   input  logic [1:0]  xn_init,
   input  logic [1:0]  xn_final,
   input  logic [2:0]  xn_event,
   input  logic [1:0]  xn_act,
   output logic        err_flag,
   output logic [2:0]  err_cause,
   output logic        asrt_valid,
   input  logic        asrt_ready,
   output logic [ADDR_W-1:0] asrt_addr,
   output logic [1:0]  asrt_kind
);

   localparam int IDX_W = $clog2(TAG_ENTRIES);
   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int REC_W = ADDR_W + 2;
   localparam int CNT_W = $clog2(Q_DEPTH + 1);

   if (TAG_ENTRIES < 2 || (TAG_ENTRIES & (TAG_ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("coh_xn_checker: TAG_ENTRIES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("coh_xn_checker: ADDR_W must exceed the index width");
   end
   if (Q_DEPTH < 1) begin : g_bad_depth
      $error("coh_xn_checker: Q_DEPTH must be at least 1");
   end

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag, st_tag;
   logic             st_vld, hit;
   line_st_t         st_raw, arch_st, exp_st;
   line_act_t        exp_act;
   logic             exp_asrt;
   asrt_kind_t       exp_kind;
   logic [CAUSE_W-1:0] mis;
   logic             any_mis, fire, pass;
   logic             q_full, q_empty;
   logic [CNT_W-1:0] q_cnt;
   logic [REC_W-1:0] q_din, q_dout;
   logic             err_q;
   logic [CAUSE_W-1:0] cause_q;

   assign idx = xn_addr[IDX_W-1:0];
   assign tag = xn_addr[ADDR_W-1:IDX_W];

   cxc_tag_store #(
      .ENTRIES      (TAG_ENTRIES),
      .TAG_W        (TAG_W),
      .CLEAR_ON_INV (CLEAR_ON_INV)
   ) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (idx),
      .rd_tag (st_tag),
      .rd_vld (st_vld),
      .rd_st  (st_raw),
      .wr_en  (pass && (exp_st != arch_st)),
      .wr_idx (idx),
      .wr_tag (tag),
      .wr_st  (exp_st)
   );

   assign hit     = st_vld && (st_tag == tag);
   assign arch_st = hit ? st_raw : ST_INV;

   cxc_rules u_rules (
      .cur_st    (arch_st),
      .ev        (xn_event),
      .nxt_st    (exp_st),
      .nxt_act   (exp_act),
      .need_asrt (exp_asrt),
      .asrt_kind (exp_kind)
   );

   assign mis[0]  = (xn_init  != arch_st);
   assign mis[1]  = (xn_final != exp_st);
   assign mis[2]  = (xn_act   != exp_act);
   assign any_mis = |mis;
   assign fire    = xn_valid && xn_ready;
   assign pass    = fire && !any_mis;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         cause_q <= '0;
      end else if (fire && any_mis) begin
         err_q   <= 1'b1;
         cause_q <= cause_q | mis;
      end
   end

   assign q_din = {exp_kind, xn_addr};

   cxc_asrt_fifo #(
      .DEPTH (Q_DEPTH),
      .W     (REC_W)
   ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (pass && exp_asrt),
      .din   (q_din),
      .pop   (asrt_ready),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full),
      .cnt   (q_cnt)
   );

   assign xn_ready   = !q_full;
   assign asrt_valid = !q_empty;
   assign asrt_addr  = q_dout[ADDR_W-1:0];
   assign asrt_kind  = q_dout[REC_W-1:ADDR_W];
   assign err_flag   = err_q;
   assign err_cause  = cause_q;

endmodule

// File: rtl/cxc_props.sv
module cxc_props #(
   parameter int ADDR_W  = 16,
   parameter int Q_DEPTH = 4,
   parameter int CNT_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xn_valid,
   input logic              xn_ready,
   input logic              chk_bad,
   input logic              err_flag,
   input logic [2:0]        err_cause,
   input logic              asrt_valid,
   input logic              asrt_ready,
   input logic [ADDR_W-1:0] asrt_addr,
   input logic [1:0]        asrt_kind,
   input logic [CNT_W-1:0]  q_cnt
);

   p_sticky_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   p_cause_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_cause & $past(err_cause)) == $past(err_cause)));

   p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cause != 3'b000) == err_flag);

   p_bad_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xn_valid && xn_ready && chk_bad) |=> err_flag);

   p_no_push_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xn_valid && xn_ready && chk_bad && !(asrt_valid && asrt_ready))
      |=> (q_cnt == $past(q_cnt)));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CNT_W'(Q_DEPTH));

   p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == CNT_W'(Q_DEPTH)) |-> !xn_ready);

   p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (asrt_valid && !asrt_ready) |=>
      (asrt_valid && $stable(asrt_addr) && $stable(asrt_kind)));

endmodule

bind coh_xn_checker cxc_props #(
   .ADDR_W  (ADDR_W),
   .Q_DEPTH (Q_DEPTH),
   .CNT_W   (CNT_W)
) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .xn_valid   (xn_valid),
   .xn_ready   (xn_ready),
   .chk_bad    (any_mis),
   .err_flag   (err_flag),
   .err_cause  (err_cause),
   .asrt_valid (asrt_valid),
   .asrt_ready (asrt_ready),
   .asrt_addr  (asrt_addr),
   .asrt_kind  (asrt_kind),
   .q_cnt      (q_cnt)
);

// File: tb/sim_coh_xn_checker.sv
`timescale 1ns/1ps
module sim_coh_xn_checker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xn_valid = 1'b0;
   logic        xn_ready;
   logic [15:0] xn_addr = '0;
   logic [1:0]  xn_init = '0, xn_final = '0, xn_act = '0;
   logic [2:0]  xn_event = '0;
   logic        err_flag;
   logic [2:0]  err_cause;
   logic        asrt_valid;
   logic        asrt_ready = 1'b0;
   logic [15:0] asrt_addr;
   logic [1:0]  asrt_kind;

   always #2.5 clk = ~clk;

   coh_xn_checker u0 (
      .clk(clk), .rst_n(rst_n), .xn_valid(xn_valid), .xn_ready(xn_ready),
      .xn_addr(xn_addr), .xn_init(xn_init), .xn_final(xn_final),
      .xn_event(xn_event), .xn_act(xn_act), .err_flag(err_flag),
      .err_cause(err_cause), .asrt_valid(asrt_valid), .asrt_ready(asrt_ready),
      .asrt_addr(asrt_addr), .asrt_kind(asrt_kind)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference
   int        m_tag [16];
   bit        m_vld [16];
   bit [1:0]  m_st  [16];
   bit [17:0] m_q [$];
   bit        m_flag = 0;
   bit [2:0]  m_cause = 0;
   string     last_tag = "R1";

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(last_tag, "xn_ready", int'(xn_ready), int'(m_q.size() < 4));
      chk(last_tag, "err_flag", int'(err_flag), int'(m_flag));
      chk(last_tag, "err_cause", int'(err_cause), int'(m_cause));
      chk(last_tag, "asrt_valid", int'(asrt_valid), int'(m_q.size() > 0));
      if (m_q.size() > 0) begin
         chk(last_tag, "asrt_addr", int'(asrt_addr), int'(m_q[0][15:0]));
         chk(last_tag, "asrt_kind", int'(asrt_kind), int'(m_q[0][17:16]));
      end
   endtask

   // MSI rules from R3 and R4
   task automatic ref_rule(input bit [1:0] cur, input bit [2:0] ev,
                           output bit [1:0] nx, output bit [1:0] ac);
      nx = cur; ac = 2'b00;
      if (cur == 2'b00) begin
         if (ev == 3'd0) nx = 2'b01;
         else if (ev == 3'd1) nx = 2'b10;
      end else if (cur == 2'b01) begin
         if (ev == 3'd1) nx = 2'b10;
         else if (ev == 3'd3 || ev == 3'd4) nx = 2'b00;
         else if (ev == 3'd2) ac = 2'b10;
      end else if (cur == 2'b10) begin
         if (ev == 3'd2) begin nx = 2'b01; ac = 2'b01; end
         else if (ev == 3'd3) begin nx = 2'b00; ac = 2'b01; end
         else if (ev == 3'd4) begin nx = 2'b00; ac = 2'b11; end
      end
   endtask

   task automatic step(input string rq, input bit v, input bit [15:0] a,
                       input bit [1:0] i0, input bit [1:0] f0, input bit [2:0] ev,
                       input bit [1:0] ac, input bit pop);
      bit acc;
      int ix, tg;
      bit [1:0] arch, nx, ea;
      bit [2:0] bad;
      @(negedge clk);
      compare();
      xn_valid = v; xn_addr = a; xn_init = i0; xn_final = f0;
      xn_event = ev; xn_act = ac; asrt_ready = pop;
      last_tag = rq;
      acc = v && (m_q.size() < 4);
      if (pop && m_q.size() > 0) void'(m_q.pop_front());
      if (acc) begin
         ix = int'(a[3:0]);
         tg = int'(a[15:4]);
         arch = (m_vld[ix] && m_tag[ix] == tg) ? m_st[ix] : 2'b00;
         ref_rule(arch, ev, nx, ea);
         bad = {ac != ea, f0 != nx, i0 != arch};
         if (bad != 3'b000) begin
            m_flag = 1;
            m_cause = m_cause | bad;
         end else if (nx != arch) begin
            m_vld[ix] = 1; m_tag[ix] = tg; m_st[ix] = nx;
            if (arch == 2'b00 && nx == 2'b01) m_q.push_back({2'b00, a});
            else if (arch == 2'b00 && nx == 2'b10) m_q.push_back({2'b01, a});
            else if (arch == 2'b01 && nx == 2'b10) m_q.push_back({2'b10, a});
            else if (arch == 2'b10 && nx == 2'b00) m_q.push_back({2'b11, a});
         end
      end
   endtask

   task automatic idle(input string rq, input bit pop);
      step(rq, 0, 16'h0, 2'b00, 2'b00, 3'd0, 2'b00, pop);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 16; k++) begin m_vld[k] = 0; m_tag[k] = 0; m_st[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1", 0);
      idle("R1", 0);
      // R3 / R7: I->S, S->M enqueue; R4: M->S send data, S snoop read respond shared
      step("R3", 1, 16'h0012, 2'b00, 2'b01, 3'd0, 2'b00, 0);
      step("R3", 1, 16'h0012, 2'b01, 2'b10, 3'd1, 2'b00, 0);
      step("R7", 1, 16'h0012, 2'b10, 2'b01, 3'd2, 2'b01, 0);
      step("R4", 1, 16'h0012, 2'b01, 2'b01, 3'd2, 2'b10, 0);
      idle("R7", 1);
      idle("R7", 1);
      // I->M, M->I writeback, snoop exclusive from M
      step("R3", 1, 16'h0035, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      step("R4", 1, 16'h0035, 2'b10, 2'b00, 3'd4, 2'b11, 1);
      step("R3", 1, 16'h0047, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      step("R4", 1, 16'h0047, 2'b10, 2'b00, 3'd3, 2'b01, 1);
      step("R3", 1, 16'h0058, 2'b00, 2'b01, 3'd0, 2'b00, 1);
      step("R3", 1, 16'h0058, 2'b01, 2'b00, 3'd3, 2'b00, 1);
      step("R7", 1, 16'h0069, 2'b00, 2'b00, 3'd2, 2'b00, 1);
      repeat (5) idle("R7", 1);
      // R9: aliasing in slot 2
      step("R9", 1, 16'h0102, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      step("R9", 1, 16'h0202, 2'b00, 2'b01, 3'd0, 2'b00, 1);
      step("R9", 1, 16'h0102, 2'b00, 2'b01, 3'd0, 2'b00, 1);
      step("R9", 1, 16'h0202, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      repeat (4) idle("R9", 1);
      // R8: fill the queue and hold the fifth report
      for (int k = 0; k < 4; k++)
         step("R8", 1, 16'h1000 + 16'(k * 16), 2'b00, 2'b01, 3'd0, 2'b00, 0);
      repeat (3) step("R8", 1, 16'h1040, 2'b00, 2'b10, 3'd1, 2'b00, 0);
      step("R8", 1, 16'h1040, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      step("R8", 1, 16'h1040, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      repeat (7) idle("R8", 1);
      // R2: miss reads Invalid, wrong initial claim
      step("R2", 1, 16'h2000, 2'b01, 2'b01, 3'd0, 2'b00, 1);
      step("R2", 1, 16'h2000, 2'b00, 2'b01, 3'd0, 2'b00, 1);
      // R6: rejected report leaves state at Modified
      step("R6", 1, 16'h3000, 2'b00, 2'b10, 3'd1, 2'b00, 1);
      step("R6", 1, 16'h3000, 2'b10, 2'b01, 3'd2, 2'b00, 1);
      step("R6", 1, 16'h3000, 2'b10, 2'b00, 3'd4, 2'b11, 1);
      // R5: final mismatch then sticky
      step("R5", 1, 16'h4000, 2'b00, 2'b10, 3'd0, 2'b00, 1);
      step("R5", 1, 16'h4000, 2'b00, 2'b01, 3'd0, 2'b00, 1);
      repeat (5) idle("R5", 1);
      @(negedge clk);
      compare();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule